// File: doc/BRIEF.md
# Bounds-Checked Buffer Access Unit

This unit turns one vector memory request into a sequence of single-word memory accesses. A request names an operation (load, store or atomic add), a 64-bit set of active lanes, one 32-bit byte offset per lane, one data word per lane, and a 128-bit buffer descriptor made of four 32-bit words. For each active lane the unit adds the offset to the descriptor's 48-bit base address and compares the whole 4-byte access against the descriptor's byte limit.

Lanes whose access fits go out to a simple synchronous memory port with a one-cycle read latency. Lanes that do not fit never reach memory. A load lane gets zero back, a store lane is thrown away, and an atomic lane leaves memory untouched. Nothing traps and no lane is reported as faulted, so a software loop can run past the end of its array with no bounds branch. Lanes are served one per cycle (two cycles for an in-range load or atomic), and a one-cycle `done_o` marks the end of the request. The request inputs must stay steady while `busy_o` is high.

Top module: `rsrc_access_unit`

## Requirements
- R1: After reset the unit is idle: `busy_o`, `done_o`, `rd_valid_o` and `mem_req_o` are all low.
- R2: The memory address for a lane is the 48-bit base plus the zero-extended lane offset. The base is descriptor bits 47:0, taken as word 0 (bits 31:0) and the low half of word 1 (bits 47:32). The upper 16 bits of word 1 (descriptor bits 63:48) are ignored.
- R3: A lane is in range only when offset + 4 is at most the byte limit in word 2 (descriptor bits 95:64). The sum is formed without 32-bit wrap, so an offset of limit−3 is out of range and an offset of limit−4 is in range.
- R4: An in-range load lane reads memory and returns the word on `rd_valid_o`/`rd_lane_o`/`rd_data_o` in the cycle after the read is issued.
- R5: An out-of-range load lane returns zero for that lane and issues no memory access.
- R6: An in-range store lane writes its data word to memory. An out-of-range store lane is discarded and memory is unchanged.
- R7: An in-range atomic-add lane reads the word, writes back the old value plus the lane data, and returns the old value. An out-of-range atomic lane leaves memory unchanged and returns zero.
- R8: Word 3 (descriptor bits 127:96) must equal 0x00020000, the raw 32-bit buffer type. Any other value makes every lane out of range.
- R9: Active lanes are served in ascending lane order and inactive lanes are skipped. `done_o` pulses for one cycle once every active lane has finished, then the unit returns to idle. A request with no active lanes still produces `done_o`.
- R10: The operation code on `req_op_i` is 0 for load, 1 for store and 2 for atomic add. A start pulse is taken only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_start_i | input | 1 | Start a request (taken while idle) |
| req_op_i | input | 2 | Operation: 0 load, 1 store, 2 atomic add |
| desc_i | input | 128 | Buffer descriptor, word k at bits 32k+31:32k |
| lane_mask_i | input | 64 | Active lanes |
| lane_off_i | input | 2048 | Per-lane byte offsets, lane k at bits 32k+31:32k |
| lane_wdata_i | input | 2048 | Per-lane store or addend data |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| rd_valid_o | output | 1 | Lane result valid (load or atomic) |
| rd_lane_o | output | 6 | Lane of the result |
| rd_data_o | output | 32 | Result data (zero for out-of-range lanes) |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 48 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after a read |

## Verification
The write-back of an atomic sum and the return of that lane's old value happen in the same cycle. That cycle also takes the memory read data into the adder. The bench sets this up by sending two atomic lanes to the same offset back to back, so the second lane's old value must already include the first lane's sum. The scoreboard checks the returned old values in lane order, and then compares the whole memory model against a reference copy updated in the same ascending order.

// File: rtl/rsrc_pkg.sv
package rsrc_pkg;
  localparam int LANES     = 64;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 48;
  localparam int ACC_BYTES = 4;
  localparam logic [WORD_W-1:0] RAW_FMT = 32'h0002_0000;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_ATOM  = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } st_e;
endpackage

// File: rtl/rsrc_desc_dec.sv
module rsrc_desc_dec
  import rsrc_pkg::*;
(
  input  logic [4*WORD_W-1:0] desc_i,
  output logic [ADDR_W-1:0]   base_o,
  output logic [WORD_W-1:0]   limit_o,
  output logic                raw_ok_o
);
  logic [15:0] unused_w1_hi;

  // upper half of word 1 is masked off for unstrided raw buffers
  assign unused_w1_hi = desc_i[63:48];
  assign base_o   = {desc_i[47:32], desc_i[31:0]};
  assign limit_o  = desc_i[95:64];
  assign raw_ok_o = (desc_i[127:96] == RAW_FMT);
endmodule

// File: rtl/rsrc_lane_pick.sv
module rsrc_lane_pick #(
  parameter int N     = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     mask_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |mask_i;
endmodule

// File: rtl/rsrc_bound_chk.sv
module rsrc_bound_chk #(
  parameter int OFF_W = 32,
  parameter int BYTES = 4
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [OFF_W-1:0] limit_i,
  input  logic             raw_ok_i,
  output logic             in_range_o
);
  logic [OFF_W:0] end_b;

  // whole access must fit; extra bit stops wrap near 2^32
  assign end_b      = {1'b0, off_i} + (OFF_W+1)'(BYTES);
  assign in_range_o = raw_ok_i && (end_b <= {1'b0, limit_i});
endmodule

// File: rtl/rsrc_access_unit.sv
module rsrc_access_unit
  import rsrc_pkg::*;
#(
  parameter int NLANE = LANES,
  localparam int IDX_W = $clog2(NLANE)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_start_i,
  input  logic [1:0]              req_op_i,
  input  logic [4*WORD_W-1:0]     desc_i,
  input  logic [NLANE-1:0]        lane_mask_i,
  input  logic [NLANE*WORD_W-1:0] lane_off_i,
  input  logic [NLANE*WORD_W-1:0] lane_wdata_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    rd_valid_o,
  output logic [IDX_W-1:0]        rd_lane_o,
  output logic [WORD_W-1:0]       rd_data_o,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [WORD_W-1:0]       mem_wdata_o,
  input  logic [WORD_W-1:0]       mem_rdata_i
);
  st_e               st_q, st_d;
  logic [NLANE-1:0]  pend_q, pend_d;
  logic [IDX_W-1:0]  lane_q, lane_d;
  logic [ADDR_W-1:0] desc_base;
  logic [WORD_W-1:0] desc_limit;
  logic              desc_raw;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_any;
  logic [IDX_W-1:0]  cur_lane;
  logic              cur_in;
  op_e               op;
  logic [WORD_W-1:0] off_arr [NLANE];
  logic [WORD_W-1:0] wd_arr  [NLANE];

  for (genvar g = 0; g < NLANE; g++) begin : g_unpack
    assign off_arr[g] = lane_off_i[g*WORD_W +: WORD_W];
    assign wd_arr[g]  = lane_wdata_i[g*WORD_W +: WORD_W];
  end

  rsrc_desc_dec u_dec (
    .desc_i   (desc_i),
    .base_o   (desc_base),
    .limit_o  (desc_limit),
    .raw_ok_o (desc_raw)
  );

  rsrc_lane_pick #(.N(NLANE)) u_pick (
    .mask_i (pend_q),
    .idx_o  (pick_idx),
    .any_o  (pick_any)
  );

  assign cur_lane = (st_q == ST_WAIT) ? lane_q : pick_idx;

  rsrc_bound_chk #(.OFF_W(WORD_W), .BYTES(ACC_BYTES)) u_bnd (
    .off_i      (off_arr[cur_lane]),
    .limit_i    (desc_limit),
    .raw_ok_i   (desc_raw),
    .in_range_o (cur_in)
  );

  assign op         = op_e'(req_op_i);
  assign busy_o     = (st_q != ST_IDLE);
  assign mem_addr_o = desc_base + ADDR_W'(off_arr[cur_lane]);
  assign rd_lane_o  = cur_lane;

  always_comb begin
    st_d        = st_q;
    pend_d      = pend_q;
    lane_d      = lane_q;
    done_o      = 1'b0;
    rd_valid_o  = 1'b0;
    rd_data_o   = '0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_wdata_o = wd_arr[cur_lane];
    unique case (st_q)
      ST_IDLE: begin
        if (req_start_i) begin
          pend_d = lane_mask_i;
          st_d   = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (!pick_any) begin
          done_o = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          pend_d           = pend_q;
          pend_d[pick_idx] = 1'b0;
          lane_d           = pick_idx;
          case (op)
            OP_LOAD, OP_ATOM: begin
              if (cur_in) begin
                mem_req_o = 1'b1;
                st_d      = ST_WAIT;
              end else begin
                rd_valid_o = 1'b1;
              end
            end
            OP_STORE: begin
              mem_req_o = cur_in;
              mem_we_o  = cur_in;
            end
            default: ;
          endcase
        end
      end
      ST_WAIT: begin
        rd_valid_o = 1'b1;
        rd_data_o  = mem_rdata_i;
        if (op == OP_ATOM) begin
          // write-back and old-value return share this cycle
          mem_req_o   = 1'b1;
          mem_we_o    = 1'b1;
          mem_wdata_o = mem_rdata_i + wd_arr[cur_lane];
        end
        st_d = ST_ISSUE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
      lane_q <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      lane_q <= lane_d;
    end
  end
endmodule

// File: rtl/rsrc_access_unit_chk.sv
module rsrc_access_unit_chk
  import rsrc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              rd_valid_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] base_i,
  input logic [WORD_W-1:0] limit_i,
  input logic              raw_i
);
  logic [ADDR_W-1:0] rel;
  logic              fits;

  assign rel  = mem_addr_o - base_i;
  assign fits = (rel[ADDR_W-1:WORD_W] == '0) &&
                (({1'b0, rel[WORD_W-1:0]} + 33'd4) <= {1'b0, limit_i});

  // R3: nothing outside the limit reaches memory
  p_bounds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> fits);

  // R8: a non-raw descriptor blocks all traffic
  p_raw_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (raw_i && busy_o));

  // R4: every read gets its result one cycle later
  p_read_return_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> rd_valid_o);

  // R7: only the atomic write-back coincides with a result
  p_atom_pair_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && mem_req_o) |-> (mem_we_o && $past(mem_req_o && !mem_we_o)));

  // R9: done is followed by idle
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

bind rsrc_access_unit rsrc_access_unit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .rd_valid_o (rd_valid_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .base_i     (desc_base),
  .limit_i    (desc_limit),
  .raw_i      (desc_raw)
);

// File: tb/rsrc_access_unit_tb.sv
module rsrc_access_unit_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_start_i = 1'b0;
  logic [1:0]   req_op_i = '0;
  logic [127:0] desc_i = '0;
  logic [63:0]  lane_mask_i = '0;
  logic [2047:0] lane_off_i, lane_wdata_i;
  logic         busy_o, done_o, rd_valid_o, mem_req_o, mem_we_o;
  logic [5:0]   rd_lane_o;
  logic [31:0]  rd_data_o, mem_wdata_o;
  logic [47:0]  mem_addr_o;
  logic [31:0]  mem_rdata_i = '0;

  localparam logic [31:0] W0   = 32'hCDEF_0100;
  localparam logic [31:0] W1   = 32'h5A5A_00AB;  // junk in upper half
  localparam logic [35:0] HIGH = 36'h00A_BCDE_F0;
  localparam logic [31:0] RAW  = 32'h0002_0000;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit done_seen = 0;
  logic [31:0] off_a [64];
  logic [31:0] wd_a  [64];
  logic [31:0] mem     [1024];
  logic [31:0] ref_mem [1024];
  logic [37:0] exp_q [$];

  always #10 clk_i = ~clk_i;

  always_comb begin
    for (int i = 0; i < 64; i++) begin
      lane_off_i[i*32 +: 32]   = off_a[i];
      lane_wdata_i[i*32 +: 32] = wd_a[i];
    end
  end

  rsrc_access_unit u_dut (.*);

  function automatic int widx(logic [31:0] off);
    logic [31:0] a = 32'h100 + off;
    return int'(a[11:2]);
  endfunction

  // memory model, one-cycle read latency
  always @(posedge clk_i) begin
    if (rst_ni && mem_req_o) begin
      if (mem_addr_o[47:12] != HIGH) begin
        n_chk++; n_fail++;
        $display("FAIL R2: address %h high bits, expected %h", mem_addr_o[47:12], HIGH);
      end
      if (mem_we_o) mem[mem_addr_o[11:2]] <= mem_wdata_o;
      else          mem_rdata_i <= mem[mem_addr_o[11:2]];
    end
  end

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && rd_valid_o) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL %s: unexpected result lane %0d data %h, expected none", tag, rd_lane_o, rd_data_o);
      end else begin
        logic [37:0] e;
        e = exp_q.pop_front();
        if ({rd_lane_o, rd_data_o} != e) begin
          n_fail++;
          $display("FAIL %s: lane %0d data %h, expected lane %0d data %h",
                   tag, rd_lane_o, rd_data_o, e[37:32], e[31:0]);
        end
      end
    end
    if (rst_ni && done_o) done_seen = 1;
  end

  task automatic run_req(input string t, input logic [1:0] op, input logic [63:0] mask,
                         input logic [31:0] limit, input logic [31:0] w3);
    bit ok;
    tag = t;
    for (int i = 0; i < 64; i++) begin
      if (mask[i]) begin
        ok = (w3 == RAW) && ({1'b0, off_a[i]} + 33'd4 <= {1'b0, limit});
        case (op)
          2'd0: exp_q.push_back({6'(i), ok ? ref_mem[widx(off_a[i])] : 32'h0});
          2'd1: if (ok) ref_mem[widx(off_a[i])] = wd_a[i];
          default: begin
            exp_q.push_back({6'(i), ok ? ref_mem[widx(off_a[i])] : 32'h0});
            if (ok) ref_mem[widx(off_a[i])] = ref_mem[widx(off_a[i])] + wd_a[i];
          end
        endcase
      end
    end
    @(negedge clk_i);
    req_op_i = op; lane_mask_i = mask; desc_i = {w3, limit, W1, W0};
    done_seen = 0; req_start_i = 1'b1;
    @(negedge clk_i);
    req_start_i = 1'b0;
    for (int c = 0; c < 1000 && !done_seen; c++) @(negedge clk_i);
    n_chk++;
    if (!done_seen) begin
      n_fail++; $display("FAIL R9 (%s): done not seen, expected done pulse", t);
    end
    @(negedge clk_i);
    n_chk++;
    if (busy_o || exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R9 (%s): busy %0d pending %0d, expected 0 0", t, busy_o, exp_q.size());
      exp_q.delete();
    end
    begin
      int bad = 0;
      for (int i = 0; i < 1024; i++) if (mem[i] !== ref_mem[i]) bad++;
      n_chk++;
      if (bad != 0) begin
        n_fail++; $display("FAIL %s: %0d memory words differ, expected 0", t, bad);
      end
    end
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 32'h1000_0000 + 32'(i * 7);
      ref_mem[i] = mem[i];
    end
    for (int i = 0; i < 64; i++) begin off_a[i] = 32'(i * 4); wd_a[i] = 32'(i + 1); end
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (busy_o || done_o || rd_valid_o || mem_req_o) begin
      n_fail++; $display("FAIL R1: outputs %b%b%b%b, expected 0000", busy_o, done_o, rd_valid_o, mem_req_o);
    end
    rst_ni = 1'b1;

    // R4 R2: full mask, last lane ends exactly at the limit
    run_req("R4", 2'd0, '1, 32'd256, RAW);
    // R3 R5: limit 255 puts lane 63 at limit-3, lane 62 at limit-4 (unaligned)
    off_a[62] = 32'd251;
    run_req("R3", 2'd0, '1, 32'd255, RAW);
    off_a[62] = 32'd248;
    // R5 R9: sparse mask, lanes beyond limit return zero
    run_req("R5", 2'd0, 64'h8000_0400_0001_0022, 32'd64, RAW);
    // R6: stores, some dropped
    for (int i = 0; i < 64; i++) wd_a[i] = 32'hA000_0000 + 32'(i);
    run_req("R6", 2'd1, 64'hF000_0000_0000_00FF, 32'd20, RAW);
    // R3 R6: huge offset must not wrap into range
    off_a[7] = 32'hFFFF_FFFE; off_a[3] = 32'h20;
    run_req("R3", 2'd1, 64'h88, 32'hFFFF_FFF0, RAW);
    off_a[7] = 32'd28; off_a[3] = 32'd12;
    // R7: atomics, two lanes on one word, one lane out of range
    off_a[0] = 32'h10; off_a[1] = 32'h10; off_a[2] = 32'h14; off_a[5] = 32'h40;
    wd_a[0] = 32'd5; wd_a[1] = 32'd9; wd_a[2] = 32'd100; wd_a[5] = 32'd77;
    run_req("R7", 2'd2, 64'h27, 32'h40, RAW);
    // R8 R10: wrong type blocks load, store and atomic
    run_req("R8", 2'd0, 64'hFF, 32'd256, 32'h0002_0001);
    run_req("R8", 2'd1, 64'hFF, 32'd256, 32'h0000_0000);
    run_req("R8", 2'd2, 64'hFF, 32'd256, 32'h0012_0000);
    // R9: empty mask still completes
    run_req("R9", 2'd0, '0, 32'd256, RAW);
    // R3: limit below one access
    run_req("R3", 2'd2, 64'h1, 32'd3, RAW);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule